// File: doc/BRIEF.md
# EDO DRAM Word Controller with Periodic Refresh

This block connects a synchronous single-word request port to a 256K x 16 asynchronous EDO DRAM. Each request carries an 18-bit word address, a write flag, two byte enables and 16 bits of write data. The controller splits the address into a 9-bit row (upper bits) and a 9-bit column (lower bits). Both go out on one shared address bus. It then runs one read or early-write cycle. The RAS, the two CAS strobes, W and OE are each timed by a count of 10 ns clock cycles.

The request port uses valid/ready. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. From that edge `req_ready` stays low until the DRAM cycle and its precharge are over. During that time the requester keeps its request held, and the controller ignores it until `req_ready` returns. A read returns its data as a one-cycle pulse on `rsp_valid` with `rsp_rdata`. The response has no ready: the requester must take it when it arrives.

A free-running timer raises a refresh request at a fixed interval, 1500 clocks by default. The controller serves it as a CAS-before-RAS refresh as soon as the current cycle ends, and it does so before any waiting request. While a refresh is pending or running, `req_ready` is low. After reset the controller spends one precharge period with RAS high before it raises `req_ready`.

Top module: `edo_dram_ctrl`

## Requirements
- R1: During reset and after its release, RAS, both CAS strobes, W and OE are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` goes high within T_RP+2 clocks of reset release.
- R2: The row `req_addr[17:9]` is on `dram_addr` in the cycle before RAS falls and in the first RAS-low cycle. The column `req_addr[8:0]` is on `dram_addr` in the cycle before each CAS falls and in the cycle in which it falls.
- R3: Before each RAS fall, RAS is high for at least T_RP cycles. RAS stays low for at least T_RAS cycles. Successive RAS falls are at least T_RC cycles apart. In an access, CAS falls no earlier than T_RCD cycles after RAS falls.
- R4: A write is an early write. W is low at least one cycle before CAS falls and stays low while CAS is low. OE stays high, and `dram_dq_oe` is high with the write data on `dram_dq_out`.
- R5: Byte enable 0 selects data bits 7:0 and the lower CAS; byte enable 1 selects bits 15:8 and the upper CAS. In a write, the CAS of a disabled byte stays high for the whole cycle, so that byte keeps its old value. A write with both enables low strobes neither CAS and changes no data.
- R6: A read drives both CAS strobes low with W high and OE low. It samples `dram_dq_in` in the last RAS-low cycle and returns that word on `rsp_rdata`, with `rsp_valid` high for exactly one cycle. That cycle is the eighth cycle after the accepting edge.
- R7: The controller accepts a request only when `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after the accepting edge. A request held valid while `req_ready` is low gives exactly one DRAM cycle.
- R8: A refresh request is raised every REF_INTERVAL clocks. The refresh is a CAS-before-RAS cycle: both CAS strobes go low at least one cycle before RAS falls, and W stays high. When no access delays it, successive refreshes are exactly REF_INTERVAL clocks apart.
- R9: A pending refresh is served before any waiting request. `req_ready` is low throughout the refresh strobes.
- R10: Even under a continuous stream of requests, successive refresh RAS falls are no more than REF_INTERVAL+16 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 18 | Word address: row in 17:9, column in 8:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables for writes (bit 0 = bits 7:0) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write line, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Controller drives the data pins |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The bench uses a cycle-level DRAM model that checks every strobe edge. Reads go to addresses with row and column at their extremes (row 0 / column 511 and the reverse), so a swapped or shifted address split returns the wrong word. Single-byte writes and a write with no enables show whether a controller strobes a masked CAS, which would corrupt the neighbouring byte. A controller that serves a waiting request ahead of a pending refresh is exposed by a back-to-back request stream: its refresh gaps stretch past the bound. Idle gaps must equal the interval exactly, so an off-by-one in the timer shows up as well.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ROW  = 3'd1,
    S_RAS  = 3'd2,
    S_PRE  = 3'd3,
    S_RCAS = 3'd4,
    S_RREF = 3'd5
  } edo_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int REF_INTERVAL = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int CW = $clog2(REF_INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick     <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (tick == LAST) tick <= '0;
      else              tick <= tick + 1'b1;
      if (tick == LAST)  ref_pend <= 1'b1;
      else if (ref_ack)  ref_pend <= 1'b0;
    end
  end

  // R8: a raised request stays raised until the sequencer takes it
  assert_pend_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend && !ref_ack |=> ref_pend);

endmodule

// File: rtl/edo_req_latch.sv
module edo_req_latch #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int COL_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic [1:0]        in_be,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [COL_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic              wr_q,
  output logic [1:0]        be_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (take) begin
      row_q   <= in_addr[ADDR_W-1:COL_W];
      col_q   <= in_addr[COL_W-1:0];
      wr_q    <= in_write;
      be_q    <= in_be;
      wdata_q <= in_wdata;
    end
  end
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int T_RP   = 4,
  parameter int T_RCD  = 2,
  parameter int T_RAS  = 6,
  parameter int T_RC   = 11,
  parameter int T_CAS  = 2,
  parameter int T_RAH  = 1,
  parameter int T_CHR  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pend,
  output logic              ref_ack,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic [COL_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  input  logic              wr_q,
  input  logic [1:0]        be_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [COL_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_lcas_n,
  output logic              dram_ucas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  // RAS low long enough for the pulse limit, the CAS access and the cycle time
  localparam int RAS_LO = imax(imax(T_RAS, T_RCD + T_CAS), T_RC - T_RP - 2);
  localparam int CNT_W  = $clog2(imax(RAS_LO, T_RP) + 1);
  localparam logic [CNT_W-1:0] RAS_LAST = CNT_W'(RAS_LO - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RCD_C    = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] RAH_C    = CNT_W'(T_RAH);
  localparam logic [CNT_W-1:0] CHR_C    = CNT_W'(T_CHR);

  edo_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign req_ready = (state == S_IDLE) && !ref_pend;
  assign accept    = req_ready && req_valid;
  assign ref_ack   = (state == S_IDLE) && ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PRE;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pend)       state <= S_RCAS;
          else if (req_valid) state <= S_ROW;
        end
        S_ROW: begin
          state <= S_RAS;
          cnt   <= '0;
        end
        S_RAS: begin
          if (cnt == RAS_LAST) begin
            state <= S_PRE;
            cnt   <= '0;
            if (!wr_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RCAS: begin
          state <= S_RREF;
          cnt   <= '0;
        end
        S_RREF: begin
          if (cnt == RAS_LAST) begin
            state <= S_PRE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PRE: begin
          if (cnt == PRE_LAST) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= S_PRE;
          cnt   <= '0;
        end
      endcase
    end
  end

  logic acc_cas, ref_cas, in_write;
  always_comb begin
    acc_cas     = (state == S_RAS) && (cnt >= RCD_C);
    ref_cas     = (state == S_RCAS) || ((state == S_RREF) && (cnt < CHR_C));
    in_write    = wr_q && ((state == S_ROW) || (state == S_RAS));
    dram_ras_n  = !((state == S_RAS) || (state == S_RREF));
    dram_lcas_n = !((acc_cas && (!wr_q || be_q[0])) || ref_cas);
    dram_ucas_n = !((acc_cas && (!wr_q || be_q[1])) || ref_cas);
    dram_we_n   = !in_write;
    dram_oe_n   = !(acc_cas && !wr_q);
    dram_dq_oe  = in_write;
    dram_dq_out = wdata_q;
    dram_addr   = ((state == S_RAS) && (cnt >= RAH_C)) ? col_q : row_q;
  end

  // checker counters of strobe run lengths
  logic [7:0] ras_hi_run, ras_lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_hi_run <= '0;
      ras_lo_run <= '0;
    end else begin
      if (dram_ras_n) begin
        ras_lo_run <= '0;
        if (ras_hi_run != 8'hFF) ras_hi_run <= ras_hi_run + 1'b1;
      end else begin
        ras_hi_run <= '0;
        if (ras_lo_run != 8'hFF) ras_lo_run <= ras_lo_run + 1'b1;
      end
    end
  end

  assert_ras_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ras_hi_run >= 8'(T_RP));

  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> ras_lo_run >= 8'(T_RAS));

  assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n |-> $past(!dram_we_n));

  assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> dram_we_n && !dram_dq_oe);

  assert_mask_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n && !be_q[0] |-> dram_lcas_n);

  assert_mask_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n && !be_q[1] |-> dram_ucas_n);

  assert_cbr_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) && !dram_lcas_n |-> $past(!dram_lcas_n) && !dram_ucas_n && dram_we_n);

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 4,
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 6,
  parameter int T_RC         = 11,
  parameter int T_CAS        = 2,
  parameter int T_RAH        = 1,
  parameter int T_CHR        = 2,
  parameter int REF_INTERVAL = 1500,
  localparam int COL_W       = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [COL_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_lcas_n,
  output logic              dram_ucas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  logic              ref_pend, ref_ack, accept;
  logic [COL_W-1:0]  row_q, col_q;
  logic              wr_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wdata_q;

  edo_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pend(ref_pend)
  );

  edo_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .take(accept),
    .in_addr(req_addr), .in_write(req_write), .in_be(req_be), .in_wdata(req_wdata),
    .row_q(row_q), .col_q(col_q), .wr_q(wr_q), .be_q(be_q), .wdata_q(wdata_q)
  );

  edo_seq #(
    .COL_W(COL_W), .DATA_W(DATA_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RC(T_RC), .T_CAS(T_CAS), .T_RAH(T_RAH), .T_CHR(T_CHR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_pend(ref_pend), .ref_ack(ref_ack),
    .req_valid(req_valid), .req_ready(req_ready), .accept(accept),
    .row_q(row_q), .col_q(col_q), .wr_q(wr_q), .be_q(be_q), .wdata_q(wdata_q),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/edo_dram_ctrl_test.sv
module edo_dram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int REF_IV = 300;
  localparam int T_RP = 4, T_RCD = 2, T_RAS = 6, T_RC = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [8:0] dram_addr;
  logic ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_out;
  logic [15:0] dq_in_m = 16'h0BAD;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_dram_ctrl #(.REF_INTERVAL(REF_IV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_lcas_n(lcas_n), .dram_ucas_n(ucas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
    .dram_dq_in(dq_in_m)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- cycle-level DRAM model ----------------
  logic [15:0] mem [int];
  logic [17:0] cur_addr = '0;
  logic cur_wr = 1'b0;
  logic [1:0] cur_be = '0;
  logic p_ras = 1, p_l = 1, p_u = 1, p_we = 1;
  logic [8:0] p_addr = '0, row_m = '0;
  int cyc = 0, hi_len = 0, lo_len = 0, since = 0;
  int last_fall = -1, last_ref = -1, ref_count = 0, acc_count = 0;
  bit cbr = 0, acc_since_ref = 1, acc_before_last = 1;
  bit fell_b [2];

  function automatic logic [15:0] rd_word(input int k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic cas_now [2];
      logic cas_prev [2];
      cas_now[0] = lcas_n; cas_now[1] = ucas_n;
      cas_prev[0] = p_l;   cas_prev[1] = p_u;
      cyc++;
      if (p_ras && !ras_n) begin
        chk(hi_len >= T_RP, "R3 precharge", hi_len, T_RP);
        if (last_fall >= 0) chk(cyc - last_fall >= T_RC, "R3 cycle time", cyc - last_fall, T_RC);
        last_fall = cyc;
        lo_len = 0;
        if (!lcas_n && !ucas_n) begin
          cbr = 1;
          chk(!p_l && !p_u, "R8 cas before ras", {p_l, p_u}, 0);
          chk(we_n, "R8 we high in refresh", we_n, 1);
          if (last_ref >= 0) begin
            chk(cyc - last_ref <= REF_IV + 16, "R10 refresh gap", cyc - last_ref, REF_IV + 16);
            if (!acc_since_ref && !acc_before_last)
              chk(cyc - last_ref == REF_IV, "R8 idle refresh interval", cyc - last_ref, REF_IV);
          end
          last_ref = cyc;
          ref_count++;
          acc_before_last = acc_since_ref;
          acc_since_ref = 0;
        end else begin
          cbr = 0;
          acc_since_ref = 1;
          acc_count++;
          row_m = dram_addr;
          since = 0;
          fell_b[0] = 0; fell_b[1] = 0;
          chk(dram_addr == p_addr, "R2 row setup", dram_addr, p_addr);
          chk(dram_addr == cur_addr[17:9], "R2 row value", dram_addr, cur_addr[17:9]);
        end
      end
      if (!p_ras && ras_n) begin
        chk(lo_len >= T_RAS, "R3 ras width", lo_len, T_RAS);
        if (!cbr) begin
          chk(fell_b[0] == (cur_wr ? cur_be[0] : 1'b1), "R5 lower cas use", fell_b[0], cur_wr ? cur_be[0] : 1'b1);
          chk(fell_b[1] == (cur_wr ? cur_be[1] : 1'b1), "R5 upper cas use", fell_b[1], cur_wr ? cur_be[1] : 1'b1);
        end
        hi_len = 0;
      end
      if (!ras_n && !cbr) begin
        for (int b = 0; b < 2; b++) begin
          if (cas_prev[b] && !cas_now[b]) begin
            fell_b[b] = 1;
            chk(since >= T_RCD, "R3 ras to cas", since, T_RCD);
            chk(dram_addr == p_addr, "R2 column setup", dram_addr, p_addr);
            chk(dram_addr == cur_addr[8:0], "R2 column value", dram_addr, cur_addr[8:0]);
            if (!we_n) begin
              logic [15:0] w;
              int k;
              k = {row_m, dram_addr};
              w = rd_word(k);
              chk(!p_we, "R4 we before cas", p_we, 0);
              chk(oe_n && dq_oe, "R4 oe high and data driven", {oe_n, dq_oe}, 3);
              if (b == 0) w[7:0] = dq_out[7:0];
              else        w[15:8] = dq_out[15:8];
              mem[k] = w;
            end else begin
              chk(!oe_n, "R6 oe low in read", oe_n, 0);
            end
          end
        end
        since++;
      end
      if (!p_we && we_n && (!lcas_n || !ucas_n)) chk(0, "R4 we released under cas", we_n, 0);
      if ((cbr && !ras_n) || (ras_n && (!lcas_n || !ucas_n)))
        chk(!req_ready, "R9 ready low in refresh", req_ready, 0);
      if (!ras_n) lo_len++; else hi_len++;
      if (!ras_n && !cbr && !oe_n && !lcas_n) dq_in_m = rd_word({row_m, dram_addr});
      else dq_in_m = 16'h0BAD;
      p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n; p_addr = dram_addr;
    end
  end

  // ---------------- stimulus ----------------
  typedef struct packed {
    logic        wr;
    logic [1:0]  be;
    logic [17:0] addr;
    logic [15:0] data;  // write data, or expected read data
  } op_t;

  localparam int NOPS = 15;
  localparam op_t OPS [NOPS] = '{
    '{1'b1, 2'b11, 18'h00000, 16'hA5C3},
    '{1'b0, 2'b00, 18'h00000, 16'hA5C3},
    '{1'b1, 2'b11, 18'h3FFFF, 16'h1234},
    '{1'b0, 2'b11, 18'h3FFFF, 16'h1234},
    '{1'b1, 2'b01, 18'h3FFFF, 16'hABCD},
    '{1'b0, 2'b00, 18'h3FFFF, 16'h12CD},
    '{1'b1, 2'b10, 18'h00000, 16'h7700},
    '{1'b0, 2'b11, 18'h00000, 16'h77C3},
    '{1'b1, 2'b11, 18'h001FF, 16'h0F0F},
    '{1'b1, 2'b11, 18'h3FE00, 16'hF0F0},
    '{1'b0, 2'b11, 18'h001FF, 16'h0F0F},
    '{1'b0, 2'b11, 18'h3FE00, 16'hF0F0},
    '{1'b1, 2'b00, 18'h001FF, 16'hFFFF},
    '{1'b0, 2'b11, 18'h001FF, 16'h0F0F},
    '{1'b0, 2'b11, 18'h12345, 16'h0000}
  };

  // Holds valid while ready is low; returns at the negedge after acceptance.
  task automatic issue(input op_t o);
    req_write = o.wr; req_be = o.be; req_addr = o.addr; req_wdata = o.data;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    cur_addr = o.addr; cur_wr = o.wr; cur_be = o.be;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7 ready low after accept", req_ready, 0);
  endtask

  task automatic run_op(input op_t o);
    issue(o);
    if (!o.wr) begin
      repeat (6) @(negedge clk);
      chk(!rsp_valid, "R6 no early response", rsp_valid, 0);
      @(negedge clk);
      chk(rsp_valid, "R6 response cycle", rsp_valid, 1);
      chk(rsp_rdata == o.data, "R6 read data", rsp_rdata, o.data);
      @(negedge clk);
      chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int refs0, acc0;
    repeat (3) @(negedge clk);
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n, "R1 strobes high in reset",
        {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'h1F);
    chk(!dq_oe && !rsp_valid, "R1 outputs idle in reset", {dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n, "R1 strobes high after reset",
        {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'h1F);
    repeat (T_RP + 1) @(negedge clk);
    chk(req_ready, "R1 ready after precharge", req_ready, 1);

    // table walk
    acc0 = acc_count;
    for (int i = 0; i < NOPS; i++) run_op(OPS[i]);
    repeat (12) @(negedge clk);
    chk(acc_count - acc0 == NOPS, "R7 one cycle per request", acc_count - acc0, NOPS);

    // idle: refreshes at the exact interval
    refs0 = ref_count;
    repeat (4 * REF_IV) @(negedge clk);
    chk(ref_count - refs0 >= 3, "R8 refreshes while idle", ref_count - refs0, 3);

    // continuous stream: refresh must still win
    refs0 = ref_count;
    for (int i = 0; i < 160; i++) begin
      op_t o;
      o = '{1'b1, 2'b11, 18'(i * 1031), 16'(i * 97 + 5)};
      issue(o);
    end
    repeat (12) @(negedge clk);
    chk(ref_count - refs0 >= 5, "R10 refreshes under load", ref_count - refs0, 5);
    run_op('{1'b0, 2'b11, 18'(159 * 1031), 16'(159 * 97 + 5)});
    run_op('{1'b0, 2'b11, 18'(3 * 1031), 16'(3 * 97 + 5)});

    finish_run();
  end
endmodule